// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Sequential Read

This block is the bus-facing front end of a 2048-byte serial memory, together with the byte array behind it. It watches the clock and data lines of a two-wire (I2C) bus and samples both with the system clock. It pulls the data line low through an open-drain enable and never drives it high. A transfer opens with a start condition. The master first sends a selection byte, which the block accepts only if it carries the device type code and matches the two strap inputs. The master then sends a two-byte word address, followed either by data to store or by a repeated start that switches the transfer to reading.

Reads are served from one internal location counter, and that counter also advances after every stored byte. On a read, each master acknowledge fetches the next location. Past the top of the array the counter continues at location zero. The transfer ends when the master withholds its acknowledge and then issues a stop. A read may begin at a freshly loaded address (random read). It may also begin wherever the counter was left (current read), since a read header can be sent straight after a start.

The controller is one state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_HDR`: the selection byte is being shifted in.
- `ST_HDR_ACK`: the block is acknowledging the selection byte.
- `ST_AHI` and `ST_AHI_ACK`: the upper address byte is received, then acknowledged.
- `ST_ALO` and `ST_ALO_ACK`: the lower address byte is received, then acknowledged.
- `ST_WDAT` and `ST_WDAT_ACK`: a data byte is received, then acknowledged.
- `ST_RDAT`: a byte is being shifted out.
- `ST_RCHK`: the block samples the master's acknowledge.
- `ST_SKIP`: the block stays silent until the next start or stop.

Transitions:
- A start leads to `ST_HDR` from any state. A stop leads to `ST_IDLE` from any state.
- `ST_HDR` goes to `ST_HDR_ACK` on a match and to `ST_SKIP` on a mismatch.
- `ST_HDR_ACK` goes to `ST_RDAT` for a read and to `ST_AHI` for a write.
- `ST_AHI` leads through `ST_AHI_ACK`, `ST_ALO` and `ST_ALO_ACK` to `ST_WDAT`.
- `ST_WDAT` and `ST_WDAT_ACK` alternate.
- `ST_RDAT` goes to `ST_RCHK`.
- `ST_RCHK` returns to `ST_RDAT` on an acknowledge and goes to `ST_SKIP` on a not-acknowledge.

Top module: `serial_mem_slave`

## Requirements
- R1: While reset is held and after it is released, `sda_oe_o` is 0 and the block drives nothing until a valid selection byte has been received.
- R2: A start is SDA falling while SCL is high. It restarts reception of the selection byte from any state, including in the middle of a byte. A stop is SDA rising while SCL is high. After a stop, bytes clocked in without a new start are not acknowledged.
- R3: The selection byte is sent MSB first. Bits 7:4 must be 1010, bit 3 must be 0, and bits 2:1 must equal `sel_i[1:0]`. Bit 0 selects the direction: 1 is read and 0 is write. On a match, the block acknowledges by pulling SDA low during the ninth clock.
- R4: On a selection mismatch, the block gives no acknowledge and drives nothing for the rest of the transfer. Address and data bytes sent in that transfer are not acknowledged and change no stored byte.
- R5: After a write selection, the word address arrives as two bytes, upper byte first, and each is acknowledged. Only bits 2:0 of the upper byte are used, so the location is {upper[2:0], lower[7:0]}.
- R6: Each data byte that follows the address is stored at the counter location and acknowledged, and the counter then advances by one.
- R7: A write selection and address, followed by a repeated start and a read selection, returns the byte stored at that address, MSB first.
- R8: A read that starts directly after a start and a read selection returns the byte at the location one past the last location read or written.
- R9: When the master acknowledges a read byte, the block sends the byte at the next location.
- R10: The counter advances from 0x7FF to 0x000, both when reading and when writing.
- R11: After a read byte that the master does not acknowledge, the block releases SDA and drives nothing until the next start or stop.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sel_i | input | 2 | Static device-select straps |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The checks on the output enable assume that the master behaves correctly on the bus. It changes SDA only while SCL is low, except to form a start or a stop. It never issues a start or a stop while the block is pulling SDA low. It also holds each SCL phase for several system clocks, long enough for the synchronizers to see every level. The bench master drives with quarter-bit phases of four clocks and moves its data only in the low phase. It places starts and stops only where the block has released the line: after a write acknowledge has finished, or after a read byte that it did not acknowledge.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RCHK,
        ST_SKIP
    } smem_state_e;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
    localparam int         BYTE_W        = 8;

endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_p[g] <= 1'b1;
                    sda_p[g] <= 1'b1;
                end else begin
                    scl_p[g] <= scl_i;
                    sda_p[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_p[g] <= 1'b1;
                    sda_p[g] <= 1'b1;
                end else begin
                    scl_p[g] <= scl_p[g-1];
                    sda_p[g] <= sda_p[g-1];
                end
            end
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edges of the clock line, and data-line edges qualified by a high clock.
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smem_store.sv
module smem_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/smem_fsm.sv
module smem_fsm
    import smem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] loc,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam int          HI_W    = ADDR_W - BYTE_W;
    localparam logic [3:0]  FULL    = 4'(BYTE_W);
    localparam logic [3:0]  LASTBIT = 4'(BYTE_W - 1);

    smem_state_e       state, nxt;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [HI_W-1:0]   ahi;
    logic              mack;
    logic              hdr_match;
    logic              byte_done;

    assign hdr_match = (shreg[7:4] == DEV_TYPE_CODE) && !shreg[3] && (shreg[2:1] == sel);
    assign byte_done = scl_fall && (cnt == FULL);

    // Next-state logic.
    always_comb begin
        nxt = state;
        if (start_p) begin
            nxt = ST_HDR;
        end else if (stop_p) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_HDR:      if (byte_done) nxt = hdr_match ? ST_HDR_ACK : ST_SKIP;
                ST_HDR_ACK:  if (scl_fall) nxt = shreg[0] ? ST_RDAT : ST_AHI;
                ST_AHI:      if (byte_done) nxt = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall) nxt = ST_ALO;
                ST_ALO:      if (byte_done) nxt = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall) nxt = ST_WDAT;
                ST_WDAT:     if (byte_done) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) nxt = ST_WDAT;
                ST_RDAT:     if (scl_fall && cnt == LASTBIT) nxt = ST_RCHK;
                ST_RCHK:     if (scl_fall) nxt = mack ? ST_RDAT : ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Shift register, bit counter and location counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            ahi   <= '0;
            loc   <= '0;
            mack  <= 1'b0;
        end else if (start_p) begin
            cnt <= '0;
        end else if (!stop_p) begin
            unique case (state)
                ST_HDR, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end
                end
                ST_HDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (shreg[0]) begin
                            shreg <= rd_data;
                            loc   <= loc + ADDR_W'(1);
                        end
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        ahi <= shreg[HI_W-1:0];
                        cnt <= '0;
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        loc <= {ahi, shreg};
                        cnt <= '0;
                    end
                end
                ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        loc <= loc + ADDR_W'(1);
                        cnt <= '0;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        cnt   <= cnt + 4'd1;
                        mack  <= 1'b0;
                    end
                end
                ST_RCHK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end
                    if (scl_fall && mack) begin
                        shreg <= rd_data;
                        loc   <= loc + ADDR_W'(1);
                        cnt   <= '0;
                    end
                end
                default: begin
                    cnt <= cnt;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_data = shreg;
        unique case (state)
            ST_HDR_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT:  sda_oe = ~shreg[BYTE_W-1];
            ST_WDAT:  wr_en  = byte_done && !start_p && !stop_p;
            default:  sda_oe = 1'b0;
        endcase
    end

    // R1: nothing is driven while the bus is free.
    a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R4 and R11: a rejected or finished transfer keeps the line released.
    a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R12: the output enable moves only while the synchronised clock is low.
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R6 and R10: the end of a write acknowledge steps the counter by one, modulo the array size.
    a_r6_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WDAT_ACK && $past(scl_fall) && !$past(start_p) && !$past(stop_p))
        |-> (loc == ($past(loc) + ADDR_W'(1))));

    // R9 and R10: an acknowledged read byte steps the counter by one, modulo the array size.
    a_r9_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RCHK && $past(scl_fall) && $past(mack) && !$past(start_p) && !$past(stop_p))
        |-> (loc == ($past(loc) + ADDR_W'(1))));

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] sel_i,
    output logic       sda_oe_o
);

    import smem_pkg::*;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic              wr_en;
    logic [ADDR_W-1:0] loc;
    logic [BYTE_W-1:0] wr_data, rd_data;

    smem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    smem_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .sel      (sel_i),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .loc      (loc),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe_o)
    );

    smem_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .addr  (loc),
        .wdata (wr_data),
        .rdata (rd_data)
    );

endmodule

// File: tb/sim_serial_mem_slave.sv
`timescale 1ns/1ps
module sim_serial_mem_slave;

    localparam logic [1:0] SEL   = 2'b10;
    localparam logic [7:0] H_WR  = {4'b1010, 1'b0, SEL, 1'b0};
    localparam logic [7:0] H_RD  = {4'b1010, 1'b0, SEL, 1'b1};
    localparam int         NVEC  = 6;
    // {upper address byte, lower address byte, data}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h07_33_5A,
        24'hF7_33_C3,
        24'h00_00_11,
        24'h03_A5_E7,
        24'h05_00_00,
        24'h07_FF_FF
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    wire  sda = ~(m_low | sda_oe);

    int n_chk = 0;
    int n_bad = 0;
    int r12_bad = 0;
    logic prev_oe = 1'b0;
    logic [7:0] ref_mem [2048];

    always #2.5 clk = ~clk;

    serial_mem_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda),
        .sel_i    (SEL),
        .sda_oe_o (sda_oe)
    );

    // R12 monitor: any change of the enable while the bus clock is high is counted.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) r12_bad++;
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = ~sda; wq(); scl = 1'b0; wq();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); b[i] = sda; wq(); scl = 1'b0;
        end
        wq(); m_low = give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); m_low = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] ah, input logic [7:0] al);
        logic a;
        bus_start();
        put_byte(H_WR, a); check("R3 write header ack", a, 1'b1);
        put_byte(ah, a);   check("R5 upper address ack", a, 1'b1);
        put_byte(al, a);   check("R5 lower address ack", a, 1'b1);
    endtask

    task automatic rd_header();
        logic a;
        bus_start();
        put_byte(H_RD, a); check("R3 read header ack", a, 1'b1);
    endtask

    task automatic wr_data(input logic [10:0] loc, input logic [7:0] d);
        logic a;
        put_byte(d, a); check("R6 data ack", a, 1'b1);
        ref_mem[loc] = d;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       a;
        logic [7:0] d;

        // R1: quiet during and after reset.
        repeat (5) @(negedge clk);
        check("R1 enable in reset", sda_oe, 1'b0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 enable after reset", sda_oe, 1'b0);

        // Vector table: write each entry, then read it back with a random read (R5 R6 R7).
        for (int v = 0; v < NVEC; v++) begin
            set_addr(VEC[v][23:16], VEC[v][15:8]);
            wr_data({VEC[v][18:16], VEC[v][15:8]}, VEC[v][7:0]);
            bus_stop();
            set_addr(VEC[v][23:16], VEC[v][15:8]);
            rd_header();
            get_byte(1'b0, d);
            bus_stop();
            check("R7 random read of table entry", d, ref_mem[{VEC[v][18:16], VEC[v][15:8]}]);
        end

        // R5: the upper address bits above bit 2 are ignored.
        set_addr(8'h07, 8'h33); rd_header(); get_byte(1'b0, d); bus_stop();
        check("R5 upper bits ignored", d, 8'hC3);

        // R6 R10: three bytes written across the top of the array.
        set_addr(8'h07, 8'hFE);
        wr_data(11'h7FE, 8'h81);
        wr_data(11'h7FF, 8'h82);
        wr_data(11'h000, 8'h83);
        bus_stop();
        set_addr(8'h00, 8'h00); rd_header(); get_byte(1'b0, d); bus_stop();
        check("R10 write wrapped to zero", d, 8'h83);

        // R9 R10 R11: a sequential read across the wrap point, ending with no acknowledge.
        set_addr(8'h07, 8'hFE); rd_header();
        get_byte(1'b1, d); check("R9 first byte", d, 8'h81);
        get_byte(1'b1, d); check("R9 next byte", d, 8'h82);
        get_byte(1'b0, d); check("R10 read wrapped to zero", d, 8'h83);
        get_byte(1'b0, d); check("R11 line released after not-acknowledge", d, 8'hFF);
        bus_stop();

        // R8: a current read continues after the last location read.
        set_addr(8'h00, 8'h20);
        wr_data(11'h020, 8'h3C);
        wr_data(11'h021, 8'h4D);
        bus_stop();
        set_addr(8'h00, 8'h20); rd_header(); get_byte(1'b0, d); bus_stop();
        check("R7 read of 0x020", d, 8'h3C);
        rd_header(); get_byte(1'b0, d); bus_stop();
        check("R8 current read", d, 8'h4D);

        // R4: mismatching headers; the rest of the transfer is not acknowledged and stores nothing.
        set_addr(8'h00, 8'h50); wr_data(11'h050, 8'h77); bus_stop();
        bus_start();
        put_byte({4'b1010, 1'b0, 2'b11, 1'b0}, a); check("R4 wrong strap no ack", a, 1'b0);
        put_byte(8'h00, a); check("R4 upper address ignored", a, 1'b0);
        put_byte(8'h50, a); check("R4 lower address ignored", a, 1'b0);
        put_byte(8'hEE, a); check("R4 data ignored", a, 1'b0);
        bus_stop();
        bus_start();
        put_byte({4'b1010, 1'b1, SEL, 1'b0}, a); check("R4 bit 3 set no ack", a, 1'b0);
        bus_stop();
        bus_start();
        put_byte({4'b1011, 1'b0, SEL, 1'b0}, a); check("R4 wrong type no ack", a, 1'b0);
        bus_stop();
        bus_start();
        put_byte({4'b1010, 1'b0, 2'b01, 1'b1}, a); check("R4 wrong strap read no ack", a, 1'b0);
        get_byte(1'b0, d); check("R4 no data driven", d, 8'hFF);
        bus_stop();
        set_addr(8'h00, 8'h50); rd_header(); get_byte(1'b0, d); bus_stop();
        check("R4 stored byte unchanged", d, 8'h77);

        // R2: a start in the middle of a byte restarts header reception.
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(H_WR, a); check("R2 restart mid-byte ack", a, 1'b1);
        bus_stop();
        // R2: after a stop, a byte without a start is not acknowledged.
        put_byte(H_WR, a); check("R2 no ack after stop", a, 1'b0);
        bus_stop();

        check("R12 enable moved only with clock low", r12_bad, 0);
        finish_run();
    end

endmodule